// File: doc/BRIEF.md
# Register File with Shift and Destination Control

This block is the storage and write-back stage of a 32-bit sliced datapath. It holds a register file of 32 words of 32 bits with two independently addressed, combinational read ports. Next to it sits a separate working register, Q, that serves multiply and divide step sequences and can also act as an accumulator. The arithmetic unit sits outside the block. Its result word enters here and is written back under a 3-bit destination code.

The destination code decides four things together. It chooses whether the register file is written. It chooses whether Q is loaded. It chooses whether the written value is passed straight, moved one place toward the most significant bit (up), or moved one place toward the least significant bit (down). It chooses whether the output word shows the result or the A read port. Each move takes its entering bit from a dedicated input. The bit it pushes off appears on a dedicated output. The register-file write always targets the word named by the B read address. It happens at the rising clock edge when the active-low write enable is low.

Top module: `rf_shift_wb`

## Requirements
- R1: While `rst_n` is low, all 32 words of the register file and the Q register are cleared to zero.
- R2: `port_a` always shows the word at `addr_a` and `port_b` the word at `addr_b`, with no clock delay. When both addresses are equal, both ports show the same word.
- R3: The register file is written at a rising edge only when `wr_n` is 0 and `dest` is 2 to 7. The write goes to the word at `addr_b`. With `wr_n` at 1, or with `dest` at 0 or 1, no word changes.
- R4: The written value depends on `dest`. For 2 and 3 it is `alu_f`. For 4 and 5 it is `{ram_hi_in, alu_f[31:1]}`. For 6 and 7 it is `{alu_f[30:0], ram_lo_in}`.
- R5: At each rising edge Q takes a new value, whatever the level of `wr_n`. For `dest`=0 it loads `alu_f`. For `dest`=4 it loads `{q_hi_in, q[31:1]}`. For `dest`=6 it loads `{q[30:0], q_lo_in}`. For every other code it keeps its value.
- R6: `y_out` equals `port_a` when `dest`=2 and equals `alu_f` for every other code.
- R7: `ram_sh_out` shows `alu_f[0]` for `dest` 4 and 5. It shows `alu_f[31]` for 6 and 7. It is 0 for codes 0 to 3.
- R8: `q_sh_out` shows `q[0]` for `dest`=4 and `q[31]` for `dest`=6. It is 0 for every other code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_a | input | 5 | A read address |
| addr_b | input | 5 | B read address and write address |
| wr_n | input | 1 | Register-file write enable, active low |
| dest | input | 3 | Destination code |
| alu_f | input | 32 | Result word from the arithmetic unit |
| ram_lo_in | input | 1 | Bit entering position 0 when the write value moves up |
| ram_hi_in | input | 1 | Bit entering position 31 when the write value moves down |
| q_lo_in | input | 1 | Bit entering Q position 0 on an up move |
| q_hi_in | input | 1 | Bit entering Q position 31 on a down move |
| port_a | output | 32 | A read port |
| port_b | output | 32 | B read port |
| q | output | 32 | Q register contents |
| y_out | output | 32 | Output word |
| ram_sh_out | output | 1 | Bit pushed off the write value |
| q_sh_out | output | 1 | Bit pushed off Q |

## Verification
The bench builds the block with its default parameters: 32-bit words and 5-bit addresses. At that size, random addresses reach every one of the 32 words, including the first and the last. Both end bit positions of the up and down moves are exercised against the bench model. Every combination of the eight destination codes with both levels of the write enable falls within the random mix. Directed cases add equal A and B addresses, writes blocked by the enable, and a series of Q moves in both directions.

// File: rtl/rf_shift_wb_pkg.sv
package rf_shift_wb_pkg;

    typedef enum logic [1:0] {
        SH_NONE = 2'd0,
        SH_UP   = 2'd1,
        SH_DOWN = 2'd2
    } shift_e;

    typedef enum logic [2:0] {
        D_QREG  = 3'd0,
        D_NOP   = 3'd1,
        D_RAMA  = 3'd2,
        D_RAMF  = 3'd3,
        D_RAMQD = 3'd4,
        D_RAMD  = 3'd5,
        D_RAMQU = 3'd6,
        D_RAMU  = 3'd7
    } dest_e;

    typedef struct packed {
        logic   ram_we;
        logic   q_ld;
        shift_e ram_sh;
        shift_e q_sh;
        logic   y_from_a;
    } dest_ctl_t;

endpackage

// File: rtl/rf_dest_decode.sv
module rf_dest_decode
    import rf_shift_wb_pkg::*;
(
    input  logic [2:0] dest,
    output dest_ctl_t  ctl
);
    always_comb begin
        ctl = '{ram_we: 1'b0, q_ld: 1'b0, ram_sh: SH_NONE, q_sh: SH_NONE, y_from_a: 1'b0};
        unique case (dest_e'(dest))
            D_QREG:  ctl.q_ld = 1'b1;
            D_NOP:   ;
            D_RAMA:  begin ctl.ram_we = 1'b1; ctl.y_from_a = 1'b1; end
            D_RAMF:  ctl.ram_we = 1'b1;
            D_RAMQD: begin
                ctl.ram_we = 1'b1; ctl.ram_sh = SH_DOWN;
                ctl.q_ld   = 1'b1; ctl.q_sh   = SH_DOWN;
            end
            D_RAMD:  begin ctl.ram_we = 1'b1; ctl.ram_sh = SH_DOWN; end
            D_RAMQU: begin
                ctl.ram_we = 1'b1; ctl.ram_sh = SH_UP;
                ctl.q_ld   = 1'b1; ctl.q_sh   = SH_UP;
            end
            D_RAMU:  begin ctl.ram_we = 1'b1; ctl.ram_sh = SH_UP; end
            default: ;
        endcase
    end
endmodule

// File: rtl/rf_shifter.sv
module rf_shifter
    import rf_shift_wb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  shift_e              dir,
    input  logic [DATA_W-1:0]   din,
    input  logic                lo_in,
    input  logic                hi_in,
    output logic [DATA_W-1:0]   dout,
    output logic                bit_out
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] up_w;
    logic [DATA_W-1:0] dn_w;

    assign up_w[0]   = lo_in;
    assign dn_w[MSB] = hi_in;

    for (genvar i = 1; i < DATA_W; i++) begin : g_bit
        assign up_w[i]   = din[i-1];
        assign dn_w[i-1] = din[i];
    end

    always_comb begin
        unique case (dir)
            SH_UP:   begin dout = up_w; bit_out = din[MSB]; end
            SH_DOWN: begin dout = dn_w; bit_out = din[0];   end
            default: begin dout = din;  bit_out = 1'b0;     end
        endcase
    end
endmodule

// File: rtl/rf_regfile.sv
module rf_regfile #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ra,
    input  logic [ADDR_W-1:0] rb,
    input  logic              we,
    input  logic [DATA_W-1:0] wd,
    output logic [DATA_W-1:0] da,
    output logic [DATA_W-1:0] db
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
        end else if (we) begin
            mem[rb] <= wd;
        end
    end

    assign da = mem[ra];
    assign db = mem[rb];
endmodule

// File: rtl/rf_shift_wb.sv
module rf_shift_wb
    import rf_shift_wb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic              wr_n,
    input  logic [2:0]        dest,
    input  logic [DATA_W-1:0] alu_f,
    input  logic              ram_lo_in,
    input  logic              ram_hi_in,
    input  logic              q_lo_in,
    input  logic              q_hi_in,
    output logic [DATA_W-1:0] port_a,
    output logic [DATA_W-1:0] port_b,
    output logic [DATA_W-1:0] q,
    output logic [DATA_W-1:0] y_out,
    output logic              ram_sh_out,
    output logic              q_sh_out
);
    dest_ctl_t         ctl;
    logic [DATA_W-1:0] ram_wd;
    logic [DATA_W-1:0] q_moved;
    logic [DATA_W-1:0] q_next;
    logic              q_bit;

    rf_dest_decode u_dec (
        .dest (dest),
        .ctl  (ctl)
    );

    rf_shifter #(.DATA_W(DATA_W)) u_ram_sh (
        .dir     (ctl.ram_sh),
        .din     (alu_f),
        .lo_in   (ram_lo_in),
        .hi_in   (ram_hi_in),
        .dout    (ram_wd),
        .bit_out (ram_sh_out)
    );

    rf_shifter #(.DATA_W(DATA_W)) u_q_sh (
        .dir     (ctl.q_sh),
        .din     (q),
        .lo_in   (q_lo_in),
        .hi_in   (q_hi_in),
        .dout    (q_moved),
        .bit_out (q_bit)
    );

    rf_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra    (addr_a),
        .rb    (addr_b),
        .we    (ctl.ram_we && !wr_n),
        .wd    (ram_wd),
        .da    (port_a),
        .db    (port_b)
    );

    // Q: plain load of the result when not moving, else moved copy of itself
    always_comb begin
        if (!ctl.q_ld)              q_next = q;
        else if (ctl.q_sh == SH_NONE) q_next = alu_f;
        else                        q_next = q_moved;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_next;
    end

    assign q_sh_out = q_bit;
    assign y_out    = ctl.y_from_a ? port_a : alu_f;
endmodule

// File: rtl/rf_shift_wb_chk.sv
module rf_shift_wb_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_b,
    input logic              wr_n,
    input logic [2:0]        dest,
    input logic [DATA_W-1:0] alu_f,
    input logic [DATA_W-1:0] port_a,
    input logic [DATA_W-1:0] port_b,
    input logic [DATA_W-1:0] q,
    input logic [DATA_W-1:0] y_out,
    input logic              ram_sh_out,
    input logic              q_sh_out
);
    AST_Y_FROM_A: assert property (@(posedge clk) disable iff (!rst_n)
        (dest == 3'd2) |-> (y_out == port_a)); // R6
    AST_Y_FROM_F: assert property (@(posedge clk) disable iff (!rst_n)
        (dest != 3'd2) |-> (y_out == alu_f)); // R6
    AST_Q_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (dest == 3'd0) |=> (q == $past(alu_f))); // R5
    AST_Q_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dest != 3'd0 && dest != 3'd4 && dest != 3'd6) |=> $stable(q)); // R5
    AST_WRITE_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && dest == 3'd3) |=> (addr_b != $past(addr_b) || port_b == $past(alu_f))); // R3
    AST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_n || dest < 3'd2) |=> (addr_b != $past(addr_b) || port_b == $past(port_b))); // R3
    AST_SHOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dest < 3'd4) |-> (!ram_sh_out && !q_sh_out)); // R7
    AST_QSH_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (dest == 3'd4) |-> (q_sh_out == q[0])); // R8
endmodule

bind rf_shift_wb rf_shift_wb_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_b     (addr_b),
    .wr_n       (wr_n),
    .dest       (dest),
    .alu_f      (alu_f),
    .port_a     (port_a),
    .port_b     (port_b),
    .q          (q),
    .y_out      (y_out),
    .ram_sh_out (ram_sh_out),
    .q_sh_out   (q_sh_out)
);

// File: tb/rf_shift_wb_tb.sv
module rf_shift_wb_tb;
    localparam int DW = 32;
    localparam int AW = 5;
    localparam int NW = 1 << AW;
    localparam time CLK_P = 20ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_a = '0, addr_b = '0;
    logic          wr_n = 1'b1;
    logic [2:0]    dest = 3'd1;
    logic [DW-1:0] alu_f = '0;
    logic          ram_lo_in = 1'b0, ram_hi_in = 1'b0, q_lo_in = 1'b0, q_hi_in = 1'b0;
    logic [DW-1:0] port_a, port_b, q, y_out;
    logic          ram_sh_out, q_sh_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [DW-1:0] m_mem [NW];
    logic [DW-1:0] m_q;

    always #(CLK_P/2) clk = ~clk;

    rf_shift_wb #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr_a(addr_a), .addr_b(addr_b), .wr_n(wr_n),
        .dest(dest), .alu_f(alu_f), .ram_lo_in(ram_lo_in), .ram_hi_in(ram_hi_in),
        .q_lo_in(q_lo_in), .q_hi_in(q_hi_in), .port_a(port_a), .port_b(port_b),
        .q(q), .y_out(y_out), .ram_sh_out(ram_sh_out), .q_sh_out(q_sh_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] f_wdata(input logic [2:0] c, input logic [DW-1:0] f, input logic lo, input logic hi);
        if (c == 3'd4 || c == 3'd5) return {hi, f[DW-1:1]};
        if (c == 3'd6 || c == 3'd7) return {f[DW-2:0], lo};
        return f;
    endfunction

    function automatic logic [DW-1:0] f_qnext(input logic [2:0] c, input logic [DW-1:0] f, input logic [DW-1:0] qq, input logic lo, input logic hi);
        if (c == 3'd0) return f;
        if (c == 3'd4) return {hi, qq[DW-1:1]};
        if (c == 3'd6) return {qq[DW-2:0], lo};
        return qq;
    endfunction

    function automatic logic f_rbit(input logic [2:0] c, input logic [DW-1:0] f);
        if (c == 3'd4 || c == 3'd5) return f[0];
        if (c == 3'd6 || c == 3'd7) return f[DW-1];
        return 1'b0;
    endfunction

    function automatic logic f_qbit(input logic [2:0] c, input logic [DW-1:0] qq);
        if (c == 3'd4) return qq[0];
        if (c == 3'd6) return qq[DW-1];
        return 1'b0;
    endfunction

    // Called at a falling edge; applies one operation across the next rising edge
    task automatic op(input logic [AW-1:0] a, input logic [AW-1:0] b, input logic wn,
                      input logic [2:0] c, input logic [DW-1:0] f,
                      input logic rl, input logic rh, input logic ql, input logic qh);
        logic [DW-1:0] e_y;
        logic          wrote;
        addr_a = a; addr_b = b; wr_n = wn; dest = c; alu_f = f;
        ram_lo_in = rl; ram_hi_in = rh; q_lo_in = ql; q_hi_in = qh;
        #2ns;
        chk(port_a == m_mem[a], "R2 port_a", port_a, m_mem[a]);
        chk(port_b == m_mem[b], "R2 port_b", port_b, m_mem[b]);
        e_y = (c == 3'd2) ? m_mem[a] : f;
        chk(y_out == e_y, "R6 y_out", y_out, e_y);
        chk(ram_sh_out == f_rbit(c, f), "R7 ram_sh_out", DW'(ram_sh_out), DW'(f_rbit(c, f)));
        chk(q_sh_out == f_qbit(c, m_q), "R8 q_sh_out", DW'(q_sh_out), DW'(f_qbit(c, m_q)));
        @(posedge clk);
        wrote = !wn && (c >= 3'd2);
        if (wrote) m_mem[b] = f_wdata(c, f, rl, rh);
        m_q = f_qnext(c, f, m_q, ql, qh);
        @(negedge clk);
        chk(q == m_q, "R5 q", q, m_q);
        if (wrote) chk(port_b == m_mem[b], "R4 written word", port_b, m_mem[b]);
        else       chk(port_b == m_mem[b], "R3 word unchanged", port_b, m_mem[b]);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NW; i++) m_mem[i] = '0;
        m_q = '0;
        repeat (3) @(negedge clk);
        // R1: reset state observed through the read ports
        for (int i = 0; i < NW; i += 31) begin
            addr_a = AW'(i); addr_b = AW'(i);
            #1ns;
            chk(port_a == '0 && port_b == '0, "R1 word cleared", port_a, '0);
        end
        chk(q == '0, "R1 q cleared", q, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3/R4: plain write, then blocked writes
        op(5'd3, 5'd7, 1'b0, 3'd3, 32'hDEAD_BEEF, 0, 0, 0, 0);
        op(5'd7, 5'd7, 1'b1, 3'd3, 32'h1234_5678, 0, 0, 0, 0);   // R3 wr_n high
        op(5'd7, 5'd7, 1'b0, 3'd1, 32'h1111_2222, 0, 0, 0, 0);   // R3 code 1
        op(5'd7, 5'd7, 1'b0, 3'd0, 32'h8000_0001, 0, 0, 0, 0);   // R3 code 0, R5 load
        // R2: same address on both ports
        addr_a = 5'd7; addr_b = 5'd7; #1ns;
        chk(port_a == port_b && port_a == 32'hDEAD_BEEF, "R2 same address", port_a, 32'hDEAD_BEEF);
        // R4/R7 edge bits: down and up moves with both inserted bits set
        op(5'd0, 5'd31, 1'b0, 3'd5, 32'h0000_0001, 1, 1, 0, 0);
        op(5'd31, 5'd0, 1'b0, 3'd7, 32'h8000_0000, 1, 1, 0, 0);
        // R5/R8: Q moves in both directions, also with wr_n high
        op(5'd1, 5'd2, 1'b1, 3'd4, 32'h0, 0, 0, 1, 1);
        op(5'd1, 5'd2, 1'b0, 3'd6, 32'h0, 0, 0, 1, 0);
        op(5'd1, 5'd2, 1'b1, 3'd6, 32'h0, 0, 0, 0, 1);
        // R6: A port routed to y_out
        op(5'd31, 5'd4, 1'b0, 3'd2, 32'hCAFE_F00D, 0, 0, 0, 0);

        for (int n = 0; n < 3000; n++) begin
            logic [2:0] rc;
            rc = 3'($urandom);
            op(AW'($urandom), AW'($urandom), 1'($urandom), rc, $urandom,
               1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule